// File: doc/BRIEF.md
# Multi-Input Pulse Edge Timestamper

This block stamps the edges of several asynchronous pulse-train inputs against a free-running local tick counter. Each input comes from a peer channel, or from a loop-back monitor. It is brought into the local clock domain by a two-flop synchronizer. Every rising edge and every falling edge is recorded in a register of its own. Software can therefore work out when each sender's latest pulse started. It can also work out how long the pulse stayed high and how long it stayed low.

Each stamp is corrected for the fixed synchronizer delay, so it names the cycle in which the new level first reached the block. A sticky per-input flag reports that a full pulse has been captured, and an overrun flag reports that another pulse began before software cleared that flag. The live counter is exposed as two halves. Reading the low half with a strobe freezes the upper half in a holding register, which lets software take a coherent two-word sample and relate the local timebase to an external timer.

Top module: `edge_stamp`

## Requirements
- R1: On a rising edge of input i, the rising stamp of i becomes the counter value of the cycle in which the high level was first sampled at the clock edge. The stamp is stored 2 cycles after that edge, and the 2-cycle latency is subtracted.
- R2: Falling edges are stamped the same way, in a register separate from the rising stamp. Falling stamp minus rising stamp gives the high time in ticks. The next rising stamp minus the falling stamp gives the low time.
- R3: A stamp holds its value until the next edge of the same kind on the same input. An edge on one input leaves every stamp of the other inputs unchanged. The default configuration has 3 inputs.
- R4: The counter resets to 0, advances by 1 each cycle and wraps modulo 2^CNT_W. `cnt_lo` shows its low CNT_W/2 bits live.
- R5: In a cycle with `cnt_rd_lo` high, the upper half of the counter in that same cycle is copied into `cnt_hi_hold`. That register then holds until the next strobe, so {`cnt_hi_hold`, `cnt_lo` sampled in the strobe cycle} is the counter value of that cycle.
- R6: `pulse_done[i]` is set in the same cycle that the falling stamp updates. It stays set until a cycle with `flag_clr[i]` high clears it.
- R7: `overrun[i]` is set when a rising stamp of i is taken while `pulse_done[i]` is set and `flag_clr[i]` is low. It is cleared by `flag_clr[i]`.
- R8: After reset, every stamp, flag and `cnt_hi_hold` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | NUM_IN | Asynchronous pulse-train inputs |
| flag_clr | input | NUM_IN | Write-1 clear of pulse_done and overrun, per input |
| cnt_rd_lo | input | 1 | Strobe: low half read, freezes the upper half |
| cnt_lo | output | CNT_W/2 | Live low half of the counter |
| cnt_hi_hold | output | CNT_W-CNT_W/2 | Upper half frozen at the last strobe |
| rise_ts | output | NUM_IN*CNT_W | Rising stamps, input i at bits i*CNT_W upward |
| fall_ts | output | NUM_IN*CNT_W | Falling stamps, same packing |
| pulse_done | output | NUM_IN | Sticky pulse-captured flags |
| overrun | output | NUM_IN | Sticky overrun flags |

## Verification
The assertions check on every cycle that the low counter half steps by one and that the frozen upper half changes only on a strobe. They also check that a completed pulse never shows equal rise and fall stamps, that an overrun appears only while the done flag was set, and that a clear takes effect. Only the bench scenarios can show that the stamps carry the correct absolute times after latency correction. The same holds for the isolation between inputs, for coherence of the counter across a wrap of the low half, and for the high and low durations recovered for a range of pulse shapes, including a one-cycle pulse.

// File: rtl/edge_stamp.sv
module edge_stamp #(
  parameter int NUM_IN = 3,
  parameter int CNT_W  = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IN-1:0]           pulse_in,
  input  logic [NUM_IN-1:0]           flag_clr,
  input  logic                        cnt_rd_lo,
  output logic [CNT_W/2-1:0]          cnt_lo,
  output logic [CNT_W-CNT_W/2-1:0]    cnt_hi_hold,
  output logic [NUM_IN*CNT_W-1:0]     rise_ts,
  output logic [NUM_IN*CNT_W-1:0]     fall_ts,
  output logic [NUM_IN-1:0]           pulse_done,
  output logic [NUM_IN-1:0]           overrun
);
  localparam int HALF = CNT_W / 2;
  localparam int LAT  = 2;

  logic [CNT_W-1:0]  cnt;
  logic [NUM_IN-1:0] s1, s2, s3;
  logic [NUM_IN-1:0] rise_det, fall_det;
  logic [CNT_W-1:0]  stamp;

  assign rise_det = s2 & ~s3;
  assign fall_det = ~s2 & s3;
  assign stamp    = cnt - CNT_W'(LAT);
  assign cnt_lo   = cnt[HALF-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      s1          <= '0;
      s2          <= '0;
      s3          <= '0;
      cnt_hi_hold <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      s1  <= pulse_in;
      s2  <= s1;
      s3  <= s2;
      if (cnt_rd_lo) cnt_hi_hold <= cnt[CNT_W-1:HALF];
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    logic [CNT_W-1:0] rise_r, fall_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rise_r        <= '0;
        fall_r        <= '0;
        pulse_done[g] <= 1'b0;
        overrun[g]    <= 1'b0;
      end else begin
        if (rise_det[g]) rise_r <= stamp;
        if (fall_det[g]) fall_r <= stamp;
        if (fall_det[g])      pulse_done[g] <= 1'b1;
        else if (flag_clr[g]) pulse_done[g] <= 1'b0;
        if (rise_det[g] && pulse_done[g] && !flag_clr[g]) overrun[g] <= 1'b1;
        else if (flag_clr[g])                              overrun[g] <= 1'b0;
      end
    end

    assign rise_ts[g*CNT_W +: CNT_W] = rise_r;
    assign fall_ts[g*CNT_W +: CNT_W] = fall_r;

    a_r2_pulse_has_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_done[g]) |-> (fall_r != rise_r));

    a_r7_overrun_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(overrun[g])) |-> $past(pulse_done[g]));

    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[g] && !fall_det[g]) |=> !pulse_done[g]);
  end

  a_r4_lo_steps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_lo == $past(cnt_lo) + 1'b1));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rd_lo |=> $stable(cnt_hi_hold));
endmodule

// File: tb/edge_stamp_bench.sv
module edge_stamp_bench;
  localparam int N  = 3;
  localparam int CW = 16;
  localparam int H  = CW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pulse_in = '0;
  logic [N-1:0] flag_clr = '0;
  logic cnt_rd_lo = 1'b0;
  logic [H-1:0] cnt_lo;
  logic [CW-H-1:0] cnt_hi_hold;
  logic [N*CW-1:0] rise_ts, fall_ts;
  logic [N-1:0] pulse_done, overrun;

  edge_stamp #(.NUM_IN(N), .CNT_W(CW)) u_edge_stamp (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .flag_clr(flag_clr),
    .cnt_rd_lo(cnt_rd_lo), .cnt_lo(cnt_lo), .cnt_hi_hold(cnt_hi_hold),
    .rise_ts(rise_ts), .fall_ts(fall_ts), .pulse_done(pulse_done), .overrun(overrun));

  always #10 clk = ~clk;

  logic [CW-1:0] refc;
  always @(posedge clk) refc <= rst_n ? refc + 1'b1 : '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] rs(input int i); return rise_ts[i*CW +: CW]; endfunction
  function automatic logic [CW-1:0] fs(input int i); return fall_ts[i*CW +: CW]; endfunction

  localparam int NV = 6;
  localparam int VIDX [NV] = '{0, 1, 2, 0, 2, 1};
  localparam int VHI  [NV] = '{5, 1, 12, 3, 7, 20};
  localparam int VLO  [NV] = '{9, 6, 4, 15, 5, 8};

  logic [CW-1:0] last_fall [N];

  initial begin
    logic [CW-1:0] tr, tf, ts;
    logic [H-1:0] lo_s;
    logic [CW-1:0] or_s [N], of_s [N];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(rs(i) == 0 && fs(i) == 0, "R8 stamps zero", {rs(i), fs(i)}, 0);
      last_fall[i] = '0;
    end
    chk(pulse_done == 0 && overrun == 0 && cnt_hi_hold == 0, "R8 flags zero",
        {pulse_done, overrun, cnt_hi_hold}, 0);
    chk(cnt_lo == refc[H-1:0], "R4 counter live", cnt_lo, refc[H-1:0]);

    for (int v = 0; v < NV; v++) begin
      int i;
      i = VIDX[v];
      for (int k = 0; k < N; k++) begin or_s[k] = rs(k); of_s[k] = fs(k); end
      pulse_in[i] = 1'b1; tr = refc;
      repeat (VHI[v]) @(negedge clk);
      pulse_in[i] = 1'b0; tf = refc;
      repeat (VLO[v]) @(negedge clk);
      chk(rs(i) == tr, "R1 rise stamp", rs(i), tr);
      chk(fs(i) == tf, "R2 fall stamp", fs(i), tf);
      chk(fs(i) - rs(i) == CW'(VHI[v]), "R2 high time", fs(i) - rs(i), VHI[v]);
      if (last_fall[i] != 0)
        chk(rs(i) > last_fall[i], "R2 low time positive", rs(i), last_fall[i]);
      last_fall[i] = tf;
      chk(pulse_done[i] && !overrun[i], "R6 done set", {pulse_done[i], overrun[i]}, 2);
      for (int k = 0; k < N; k++)
        if (k != i)
          chk(rs(k) == or_s[k] && fs(k) == of_s[k], "R3 others unchanged",
              {rs(k), fs(k)}, {or_s[k], of_s[k]});
      flag_clr[i] = 1'b1;
      @(negedge clk);
      flag_clr[i] = 1'b0;
      @(negedge clk);
      chk(!pulse_done[i], "R6 done cleared", pulse_done[i], 0);
    end

    pulse_in[1] = 1'b1; tr = refc;
    repeat (4) @(negedge clk);
    pulse_in[1] = 1'b0; tf = refc;
    repeat (6) @(negedge clk);
    chk(pulse_done[1] && !overrun[1], "R6 done before overrun", {pulse_done[1], overrun[1]}, 2);
    pulse_in[1] = 1'b1; ts = refc;
    repeat (4) @(negedge clk);
    chk(overrun[1], "R7 overrun set", overrun[1], 1);
    chk(rs(1) == ts && fs(1) == tf, "R3 new rise, fall kept", {rs(1), fs(1)}, {ts, tf});
    chk(rs(1) - tr == 10, "R2 period from rises", rs(1) - tr, 10);
    flag_clr[1] = 1'b1;
    @(negedge clk);
    flag_clr[1] = 1'b0;
    @(negedge clk);
    chk(!overrun[1] && !pulse_done[1], "R7 overrun cleared", {overrun[1], pulse_done[1]}, 0);
    pulse_in[1] = 1'b0;
    repeat (5) @(negedge clk);

    while (refc[H-1:0] != {H{1'b1}}) @(negedge clk);
    cnt_rd_lo = 1'b1; lo_s = cnt_lo; ts = refc;
    @(negedge clk);
    cnt_rd_lo = 1'b0;
    chk({cnt_hi_hold, lo_s} == ts, "R5 coherent read at wrap", {cnt_hi_hold, lo_s}, ts);
    repeat (3) @(negedge clk);
    chk(cnt_hi_hold == ts[CW-1:H], "R5 hold stable", cnt_hi_hold, ts[CW-1:H]);
    chk(refc[CW-1:H] != ts[CW-1:H], "R5 upper half moved", refc[CW-1:H], ts[CW-1:H] + 1);
    chk(cnt_lo == refc[H-1:0], "R4 counter wrapped low", cnt_lo, refc[H-1:0]);
    cnt_rd_lo = 1'b1; lo_s = cnt_lo; ts = refc;
    @(negedge clk);
    cnt_rd_lo = 1'b0;
    chk({cnt_hi_hold, lo_s} == ts, "R5 second read", {cnt_hi_hold, lo_s}, ts);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rs(0) == 0 && fs(2) == 0 && cnt_hi_hold == 0 && pulse_done == 0, "R8 reset again",
        {rs(0), fs(2), cnt_hi_hold}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule